// File: doc/BRIEF.md
# Subroutine call and return sequencer

This block carries out the stack side of subroutine linkage for an 8-bit microcontroller core. When the core hands it an opcode, up to two operand bytes and the address of the opcode byte, the block recognises six operations. These are the in-page call, the long call, the return, the return from interrupt, and single-byte push and pop. It then steps through the internal-RAM accesses that each operation needs, one access per clock.

For a call it works out both the return address and the target. It stores the return address on the stack one byte per cycle, low byte first, and then presents the target on `pc_out`. A return reads the two bytes back, high byte first, and rebuilds the program counter from them. Push copies one internal-RAM byte onto the stack, and pop copies the top of the stack into an internal-RAM byte. The stack pointer lives inside the block. It is pre-incremented before every write and post-decremented after every read.

The core pulses `start` for one cycle. It must hold `in_service` steady while `busy` is high. It takes the new program counter when `done` pulses.

Top module: `call_ret_seq`

## Requirements
- R1: After reset the stack pointer is 0x07, `busy`, `done`, `ram_we`, `ram_rd` and `isr_release` are low, and `pc_out` is 0x0000.
- R2: An opcode whose bits 4:0 are 0b10001 is an in-page call. Its return address is `pc_in`+2. Its target takes bits 15:11 from the return address, bits 10:8 from opcode bits 7:5, and bits 7:0 from `operand1`.
- R3: Opcode 0x12 is a long call. Its return address is `pc_in`+3, and its target is `{operand1, operand2}`, with `operand1` as the high byte.
- R4: A call writes the return address in two consecutive cycles, first the low byte at SP+1 and then the high byte at SP+2. The stack pointer ends 2 higher.
- R5: Opcode 0x22 is a return. It reads at SP in one cycle and at SP-1 in the next, and the stack pointer ends 2 lower. `pc_out` becomes `{first byte read, second byte read}`.
- R6: Opcode 0x32 behaves exactly like R5. In addition, `isr_release` pulses together with `done` when `in_service` is high, and stays low when `in_service` is low.
- R7: Opcode 0xC0 is a push. It reads internal RAM at `operand1`, then writes that byte at SP+1, and the stack pointer ends 1 higher.
- R8: Opcode 0xD0 is a pop. It reads at SP, then writes that byte to internal RAM at `operand1`, and the stack pointer ends 1 lower.
- R9: The stack pointer wraps from 0xFF to 0x00 and from 0x00 to 0xFF, and gives no other indication of the wrap.
- R10: `busy` goes high in the cycle after an accepted `start`. RAM accesses follow in consecutive cycles. `done` is a one-cycle pulse in the cycle after the last step. `pc_out` changes only together with `done`, and it never changes for push or pop.
- R11: A `start` with any other opcode, or a `start` raised while `busy` is high, is ignored. No RAM access occurs, and the stack pointer and `pc_out` stay the same.
- R12: RAM read data is taken on `ram_rdata` in the cycle after the cycle in which `ram_rd` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to run the operation in `opcode` |
| opcode | input | 8 | Decoded instruction opcode |
| operand1 | input | 8 | First byte after the opcode |
| operand2 | input | 8 | Second byte after the opcode |
| pc_in | input | 16 | Address of the opcode byte |
| in_service | input | 1 | An interrupt handler is currently running |
| ram_rdata | input | 8 | Internal RAM read data, one cycle after `ram_rd` |
| ram_we | output | 1 | Internal RAM write strobe |
| ram_rd | output | 1 | Internal RAM read strobe |
| ram_addr | output | 8 | Internal RAM address |
| ram_wdata | output | 8 | Internal RAM write data |
| sp | output | 8 | Stack pointer |
| pc_out | output | 16 | New program counter, valid when `done` pulses |
| busy | output | 1 | Stack sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| isr_release | output | 1 | One-cycle pulse that clears the in-service flag |

## Verification
The bench builds the block with its default parameters: 8-bit data, a reset stack pointer of 0x07, and the in-page call decode enabled. With the 0x07 reset value, eight pops drive the pointer to 0xFF in a few dozen cycles, so calls, returns, pushes and pops all cross both wrap points. With in-page calls enabled, all eight pages can be checked. A return address that crosses a 2 KB boundary is also exercised, because it changes the upper target bits.

// File: rtl/call_ret_pkg.sv
package call_ret_pkg;

   localparam logic [7:0] OPC_LCALL = 8'h12;
   localparam logic [7:0] OPC_RET   = 8'h22;
   localparam logic [7:0] OPC_RETI  = 8'h32;
   localparam logic [7:0] OPC_PUSH  = 8'hC0;
   localparam logic [7:0] OPC_POP   = 8'hD0;
   localparam logic [4:0] ACALL_LOW = 5'b10001;

   typedef enum logic [2:0] {
      K_NONE, K_ACALL, K_LCALL, K_RET, K_RETI, K_PUSH, K_POP
   } op_kind_t;

   typedef enum logic [2:0] {
      ST_IDLE, ST_PUSH_LO, ST_PUSH_HI, ST_FETCH,
      ST_STORE, ST_POP_HI, ST_POP_LO, ST_LOAD
   } seq_state_t;

endpackage

// File: rtl/crs_decode.sv
module crs_decode
   import call_ret_pkg::*;
#(
   parameter bit ACALL_EN = 1'b1
) (
   input  logic [7:0] opcode,
   output op_kind_t   kind
);

   logic is_acall;

   generate
      if (ACALL_EN) begin : g_acall
         assign is_acall = (opcode[4:0] == ACALL_LOW);
      end else begin : g_no_acall
         assign is_acall = 1'b0;
      end
   endgenerate

   always_comb begin
      kind = K_NONE;
      if (is_acall) begin
         kind = K_ACALL;
      end else begin
         case (opcode)
            OPC_LCALL: kind = K_LCALL;
            OPC_RET:   kind = K_RET;
            OPC_RETI:  kind = K_RETI;
            OPC_PUSH:  kind = K_PUSH;
            OPC_POP:   kind = K_POP;
            default:   kind = K_NONE;
         endcase
      end
   end

endmodule

// File: rtl/crs_target.sv
module crs_target
   import call_ret_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PAGE_W = 3,
   localparam int PC_W  = 2 * DATA_W,
   localparam int OFF_W = DATA_W + PAGE_W
) (
   input  op_kind_t          kind,
   input  logic [PAGE_W-1:0] page,
   input  logic [DATA_W-1:0] op_hi,
   input  logic [DATA_W-1:0] op_lo,
   input  logic [PC_W-1:0]   pc_in,
   output logic [PC_W-1:0]   ret_addr,
   output logic [PC_W-1:0]   target
);

   logic [PC_W-1:0] step;
   logic [PC_W-1:0] page_tgt;
   logic [PC_W-1:0] long_tgt;

   assign step     = (kind == K_LCALL) ? PC_W'(3) : PC_W'(2);
   assign ret_addr = pc_in + step;
   // In-page target keeps the block bits of the following instruction
   assign page_tgt = {ret_addr[PC_W-1:OFF_W], page, op_hi};
   assign long_tgt = {op_hi, op_lo};
   assign target   = (kind == K_ACALL) ? page_tgt : long_tgt;

endmodule

// File: rtl/crs_stack_ptr.sv
module crs_stack_ptr #(
   parameter int               SP_W     = 8,
   parameter logic [SP_W-1:0]  SP_RESET = 8'h07
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            inc,
   input  logic            dec,
   output logic [SP_W-1:0] sp,
   output logic [SP_W-1:0] sp_up
);

   assign sp_up = sp + SP_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sp <= SP_RESET;
      else if (inc) sp <= sp_up;
      else if (dec) sp <= sp - SP_W'(1);
   end

endmodule

// File: rtl/crs_fsm.sv
module crs_fsm
   import call_ret_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int PC_W  = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  op_kind_t          kind,
   input  logic [PC_W-1:0]   ret_addr,
   input  logic [PC_W-1:0]   target,
   input  logic [DATA_W-1:0] arg,
   input  logic [DATA_W-1:0] ram_rdata,
   input  logic              in_service,
   input  logic [DATA_W-1:0] sp,
   input  logic [DATA_W-1:0] sp_up,
   output logic              sp_inc,
   output logic              sp_dec,
   output logic              ram_we,
   output logic              ram_rd,
   output logic [DATA_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   output logic              busy,
   output logic              done,
   output logic [PC_W-1:0]   pc_out,
   output logic              isr_release
);

   seq_state_t        state, nxt;
   op_kind_t          kind_q;
   logic [PC_W-1:0]   ret_q, tgt_q, pc_q;
   logic [DATA_W-1:0] arg_q, hi_q;
   logic              done_q, rel_q;
   logic              accept;

   assign accept      = start && (state == ST_IDLE) && (kind != K_NONE);
   assign busy        = (state != ST_IDLE);
   assign done        = done_q;
   assign pc_out      = pc_q;
   assign isr_release = rel_q;

   always_comb begin
      nxt       = state;
      sp_inc    = 1'b0;
      sp_dec    = 1'b0;
      ram_we    = 1'b0;
      ram_rd    = 1'b0;
      ram_addr  = '0;
      ram_wdata = '0;
      case (state)
         ST_IDLE: begin
            if (accept) begin
               case (kind)
                  K_ACALL, K_LCALL: nxt = ST_PUSH_LO;
                  K_PUSH:           nxt = ST_FETCH;
                  default:          nxt = ST_POP_HI;
               endcase
            end
         end
         ST_PUSH_LO: begin
            ram_we    = 1'b1;
            ram_addr  = sp_up;
            ram_wdata = ret_q[DATA_W-1:0];
            sp_inc    = 1'b1;
            nxt       = ST_PUSH_HI;
         end
         ST_PUSH_HI: begin
            ram_we    = 1'b1;
            ram_addr  = sp_up;
            ram_wdata = ret_q[PC_W-1:DATA_W];
            sp_inc    = 1'b1;
            nxt       = ST_IDLE;
         end
         ST_FETCH: begin
            ram_rd   = 1'b1;
            ram_addr = arg_q;
            nxt      = ST_STORE;
         end
         ST_STORE: begin
            ram_we    = 1'b1;
            ram_wdata = ram_rdata;
            if (kind_q == K_PUSH) begin
               ram_addr = sp_up;
               sp_inc   = 1'b1;
            end else begin
               ram_addr = arg_q;
            end
            nxt = ST_IDLE;
         end
         ST_POP_HI: begin
            ram_rd   = 1'b1;
            ram_addr = sp;
            sp_dec   = 1'b1;
            nxt      = (kind_q == K_POP) ? ST_STORE : ST_POP_LO;
         end
         ST_POP_LO: begin
            ram_rd   = 1'b1;
            ram_addr = sp;
            sp_dec   = 1'b1;
            nxt      = ST_LOAD;
         end
         ST_LOAD: nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         kind_q <= K_NONE;
         ret_q  <= '0;
         tgt_q  <= '0;
         arg_q  <= '0;
         hi_q   <= '0;
         pc_q   <= '0;
         done_q <= 1'b0;
         rel_q  <= 1'b0;
      end else begin
         state  <= nxt;
         done_q <= (state == ST_PUSH_HI) || (state == ST_STORE) || (state == ST_LOAD);
         rel_q  <= (state == ST_LOAD) && (kind_q == K_RETI) && in_service;
         if (accept) begin
            kind_q <= kind;
            ret_q  <= ret_addr;
            tgt_q  <= target;
            arg_q  <= arg;
         end
         if (state == ST_POP_LO) hi_q <= ram_rdata;
         if (state == ST_PUSH_HI) pc_q <= tgt_q;
         if (state == ST_LOAD)    pc_q <= {hi_q, ram_rdata};
      end
   end

endmodule

// File: rtl/call_ret_seq.sv
module call_ret_seq
   import call_ret_pkg::*;
#(
   parameter int          DATA_W   = 8,
   parameter logic [7:0]  SP_RESET = 8'h07,
   parameter bit          ACALL_EN = 1'b1,
   localparam int         PC_W     = 2 * DATA_W,
   localparam int         PAGE_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        opcode,
   input  logic [DATA_W-1:0] operand1,
   input  logic [DATA_W-1:0] operand2,
   input  logic [PC_W-1:0]   pc_in,
   input  logic              in_service,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic              ram_we,
   output logic              ram_rd,
   output logic [DATA_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   output logic [DATA_W-1:0] sp,
   output logic [PC_W-1:0]   pc_out,
   output logic              busy,
   output logic              done,
   output logic              isr_release
);

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("call_ret_seq: opcode layout needs DATA_W of 8");
      end
   endgenerate

   op_kind_t          kind;
   logic [PC_W-1:0]   ret_addr, target;
   logic [DATA_W-1:0] sp_up;
   logic              sp_inc, sp_dec;

   crs_decode #(.ACALL_EN(ACALL_EN)) u_decode (
      .opcode (opcode),
      .kind   (kind)
   );

   crs_target #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_target (
      .kind     (kind),
      .page     (opcode[7 -: PAGE_W]),
      .op_hi    (operand1),
      .op_lo    (operand2),
      .pc_in    (pc_in),
      .ret_addr (ret_addr),
      .target   (target)
   );

   crs_stack_ptr #(.SP_W(DATA_W), .SP_RESET(SP_RESET)) u_sp (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (sp_inc),
      .dec   (sp_dec),
      .sp    (sp),
      .sp_up (sp_up)
   );

   crs_fsm #(.DATA_W(DATA_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .kind        (kind),
      .ret_addr    (ret_addr),
      .target      (target),
      .arg         (operand1),
      .ram_rdata   (ram_rdata),
      .in_service  (in_service),
      .sp          (sp),
      .sp_up       (sp_up),
      .sp_inc      (sp_inc),
      .sp_dec      (sp_dec),
      .ram_we      (ram_we),
      .ram_rd      (ram_rd),
      .ram_addr    (ram_addr),
      .ram_wdata   (ram_wdata),
      .busy        (busy),
      .done        (done),
      .pc_out      (pc_out),
      .isr_release (isr_release)
   );

endmodule

// File: rtl/crs_checker.sv
module crs_checker #(
   parameter int DATA_W = 8,
   localparam int PC_W  = 2 * DATA_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ram_we,
   input logic              ram_rd,
   input logic [DATA_W-1:0] sp,
   input logic [PC_W-1:0]   pc_out,
   input logic              busy,
   input logic              done,
   input logic              isr_release
);

   AST_SP_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (sp != $past(sp)) |-> ((sp == $past(sp) + DATA_W'(1)) || (sp == $past(sp) - DATA_W'(1)))); // R9

   AST_SP_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(busy) |-> $stable(sp)); // R11

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10

   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy)); // R10

   AST_PC_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pc_out) |-> done); // R10

   AST_RAM_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_we && ram_rd)); // R12

   AST_RAM_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we || ram_rd) |-> busy); // R11

   AST_RELEASE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      isr_release |-> done); // R6

endmodule

bind call_ret_seq crs_checker #(.DATA_W(DATA_W)) u_crs_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .ram_we      (ram_we),
   .ram_rd      (ram_rd),
   .sp          (sp),
   .pc_out      (pc_out),
   .busy        (busy),
   .done        (done),
   .isr_release (isr_release)
);

// File: tb/call_ret_seq_bench.sv
`timescale 1ns/1ps
module call_ret_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  opcode = 8'h00, operand1 = 8'h00, operand2 = 8'h00;
   logic [15:0] pc_in = 16'h0000;
   logic        in_service = 1'b0;
   logic [7:0]  ram_rdata;
   logic        ram_we, ram_rd, busy, done, isr_release;
   logic [7:0]  ram_addr, ram_wdata, sp;
   logic [15:0] pc_out;

   logic [7:0]  ram [256];
   int          n_chk = 0, n_fail = 0;
   bit          finished = 1'b0;
   logic [7:0]  sp_m = 8'h07;
   logic [15:0] pc_m = 16'h0000;

   always #2.5 clk = ~clk;

   call_ret_seq u_call_ret_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .operand1(operand1), .operand2(operand2), .pc_in(pc_in),
      .in_service(in_service), .ram_rdata(ram_rdata), .ram_we(ram_we),
      .ram_rd(ram_rd), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .sp(sp),
      .pc_out(pc_out), .busy(busy), .done(done), .isr_release(isr_release)
   );

   // Internal RAM environment with one-cycle read latency (R12)
   always @(posedge clk) begin
      if (ram_we) ram[ram_addr] <= ram_wdata;
      if (ram_rd) ram_rdata <= ram[ram_addr];
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic run_op(input logic [7:0] opc, input logic [7:0] o1, input logic [7:0] o2,
                         input logic [15:0] pcv, input bit isr, input bit poke,
                         input string req);
      logic        e_busy[5], e_done[5], e_we[5], e_rd[5], e_rel[5];
      logic [7:0]  e_addr[5], e_wd[5], e_sp[5];
      logic [15:0] e_pc[5];
      logic [15:0] ret, tgt;
      int          n;
      for (int i = 0; i < 5; i++) begin
         e_busy[i] = 0; e_done[i] = 0; e_we[i] = 0; e_rd[i] = 0; e_rel[i] = 0;
         e_addr[i] = 0; e_wd[i] = 0; e_sp[i] = sp_m; e_pc[i] = pc_m;
      end
      if (opc[4:0] == 5'h11 || opc == 8'h12) begin
         ret = (opc == 8'h12) ? pcv + 16'd3 : pcv + 16'd2;
         tgt = (opc == 8'h12) ? {o1, o2} : {ret[15:11], opc[7:5], o1};
         e_busy[0] = 1; e_we[0] = 1; e_addr[0] = sp_m + 8'd1; e_wd[0] = ret[7:0];
         e_busy[1] = 1; e_we[1] = 1; e_addr[1] = sp_m + 8'd2; e_wd[1] = ret[15:8];
         e_sp[1] = sp_m + 8'd1;
         e_done[2] = 1; e_pc[2] = tgt; e_sp[2] = sp_m + 8'd2;
         e_sp[3] = sp_m + 8'd2; e_pc[3] = tgt;
         n = 4; sp_m = sp_m + 8'd2; pc_m = tgt;
      end else if (opc == 8'h22 || opc == 8'h32) begin
         tgt = {ram[sp_m], ram[sp_m - 8'd1]};
         e_busy[0] = 1; e_rd[0] = 1; e_addr[0] = sp_m;
         e_busy[1] = 1; e_rd[1] = 1; e_addr[1] = sp_m - 8'd1; e_sp[1] = sp_m - 8'd1;
         e_busy[2] = 1; e_sp[2] = sp_m - 8'd2;
         e_done[3] = 1; e_pc[3] = tgt; e_sp[3] = sp_m - 8'd2;
         e_rel[3] = (opc == 8'h32) && isr;
         e_sp[4] = sp_m - 8'd2; e_pc[4] = tgt;
         n = 5; sp_m = sp_m - 8'd2; pc_m = tgt;
      end else if (opc == 8'hC0) begin
         e_busy[0] = 1; e_rd[0] = 1; e_addr[0] = o1;
         e_busy[1] = 1; e_we[1] = 1; e_addr[1] = sp_m + 8'd1; e_wd[1] = ram[o1];
         e_done[2] = 1; e_sp[2] = sp_m + 8'd1; e_sp[3] = sp_m + 8'd1;
         n = 4; sp_m = sp_m + 8'd1;
      end else if (opc == 8'hD0) begin
         e_busy[0] = 1; e_rd[0] = 1; e_addr[0] = sp_m;
         e_busy[1] = 1; e_we[1] = 1; e_addr[1] = o1; e_wd[1] = ram[sp_m];
         e_sp[1] = sp_m - 8'd1;
         e_done[2] = 1; e_sp[2] = sp_m - 8'd1; e_sp[3] = sp_m - 8'd1;
         n = 4; sp_m = sp_m - 8'd1;
      end else begin
         n = 3;
      end
      @(negedge clk);
      opcode = opc; operand1 = o1; operand2 = o2; pc_in = pcv; in_service = isr;
      start = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (i == 0) begin
            start = 1'b0;
            if (poke) begin
               start = 1'b1; opcode = 8'h22; operand1 = 8'h5A;
            end
         end else if (i == 1) begin
            start = 1'b0;
         end
         chk(busy === e_busy[i], req, "busy", 16'(busy), 16'(e_busy[i]));
         chk(done === e_done[i], req, "done", 16'(done), 16'(e_done[i]));
         chk(ram_we === e_we[i], req, "ram_we", 16'(ram_we), 16'(e_we[i]));
         chk(ram_rd === e_rd[i], req, "ram_rd", 16'(ram_rd), 16'(e_rd[i]));
         if (e_we[i] || e_rd[i])
            chk(ram_addr === e_addr[i], req, "ram_addr", 16'(ram_addr), 16'(e_addr[i]));
         if (e_we[i])
            chk(ram_wdata === e_wd[i], req, "ram_wdata", 16'(ram_wdata), 16'(e_wd[i]));
         chk(sp === e_sp[i], req, "sp", 16'(sp), 16'(e_sp[i]));
         chk(pc_out === e_pc[i], req, "pc_out", pc_out, e_pc[i]);
         chk(isr_release === e_rel[i], req, "isr_release", 16'(isr_release), 16'(e_rel[i]));
      end
   endtask

   initial begin
      for (int i = 0; i < 256; i++) ram[i] = 8'(i * 37 + 11);
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(sp === 8'h07, "R1", "sp", 16'(sp), 16'h0007);
      chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done", {14'd0, busy, done}, 16'h0);
      chk(ram_we === 1'b0 && ram_rd === 1'b0, "R1", "ram strobes", {14'd0, ram_we, ram_rd}, 16'h0);
      chk(pc_out === 16'h0000 && isr_release === 1'b0, "R1", "pc_out", pc_out, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sp === 8'h07 && !busy, "R1", "sp after release", 16'(sp), 16'h0007);

      // In-page calls on every page, each undone by a return
      for (int p = 0; p < 8; p++) begin
         run_op({3'(p), 5'b10001}, 8'(p * 29 + 4), 8'h99, 16'h1234 + 16'(p * 256),
                1'b0, 1'b0, "R2 R4 R10");
         run_op(8'h22, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b0, "R5 R10");
      end
      // Return address crossing a 2 KB block boundary
      run_op(8'hF1, 8'h3C, 8'h00, 16'hF7FE, 1'b0, 1'b0, "R2 boundary");
      run_op(8'h22, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b0, "R5");
      // Long calls, nested, then returns
      run_op(8'h12, 8'hAB, 8'hCD, 16'h0FFE, 1'b0, 1'b0, "R3 R4");
      run_op(8'h12, 8'h00, 8'h10, 16'hFFFE, 1'b0, 1'b0, "R3 R4 wrap of pc");
      run_op(8'h32, 8'h00, 8'h00, 16'h0000, 1'b1, 1'b0, "R6 in service");
      run_op(8'h32, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b0, "R6 not in service");
      // Push and pop, pc_out must hold
      run_op(8'hC0, 8'h40, 8'h00, 16'h0000, 1'b0, 1'b0, "R7 R10");
      run_op(8'hC0, 8'h41, 8'h00, 16'h0000, 1'b0, 1'b0, "R7");
      run_op(8'hD0, 8'h50, 8'h00, 16'h0000, 1'b0, 1'b0, "R8 R10");
      run_op(8'hD0, 8'h51, 8'h00, 16'h0000, 1'b0, 1'b0, "R8");
      chk(ram[8'h50] === ram[8'h41], "R8", "popped byte", 16'(ram[8'h50]), 16'(ram[8'h41]));
      // Ignored starts
      run_op(8'h00, 8'h10, 8'h20, 16'h0100, 1'b0, 1'b0, "R11 opcode 00");
      run_op(8'hA5, 8'h10, 8'h20, 16'h0100, 1'b0, 1'b0, "R11 opcode A5");
      run_op(8'h13, 8'h10, 8'h20, 16'h0100, 1'b1, 1'b0, "R11 opcode 13");
      run_op(8'h12, 8'h77, 8'h66, 16'h2000, 1'b0, 1'b1, "R11 start while busy");
      run_op(8'h22, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b0, "R5 after ignored start");
      // Stack pointer wrap both ways
      for (int i = 0; i < 8; i++)
         run_op(8'hD0, 8'(8'h60 + i), 8'h00, 16'h0000, 1'b0, 1'b0, "R9 R8 down");
      chk(sp === 8'hFF, "R9", "sp after wrap down", 16'(sp), 16'h00FF);
      run_op(8'h12, 8'h3E, 8'h21, 16'h4567, 1'b0, 1'b0, "R9 R4 call across wrap");
      run_op(8'h22, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b0, "R9 R5 return across wrap");
      run_op(8'hC0, 8'h20, 8'h00, 16'h0000, 1'b0, 1'b0, "R9 R7 push across wrap");
      run_op(8'hD0, 8'h61, 8'h00, 16'h0000, 1'b0, 1'b0, "R9 R8 pop across wrap");
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule